// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This block gathers the status of a multi-output instrument into a small hierarchy of event and summary registers in the style of IEEE 488.2. Each output supplies three condition levels: current limit, voltage limit and trip. Any change of a condition, entering or leaving, is caught as an edge and latched as a sticky bit in a limit event register. A mask selects which of those bits feed a limit summary bit in the status byte.

The status byte also carries a standard-event summary that arrives precomputed, a fault flag and a message-available flag. A service request enable mask chooses which status byte bits raise the master summary. The master summary is live and combinational. A request latch captures each rising edge of the master summary and drives the service request output. A normal status read shows the live summary in bit 6. A serial poll shows the latched request in bit 6 and clears it.

A simple register port reads and clears the limit event register, writes and reads both masks, reads the status byte and performs the serial poll. Read data appears one cycle after the request.

Top module: `stat_report_unit`

## Requirements
- R1: After reset, every register reads as zero, `srq_o` is low and `bus_rvalid_o` is low.
- R2: A rising or falling edge on a condition input sets the event bit at index 3k+c and keeps it set until the event register is read. Here k is the output number and c is 0 for current limit, 1 for voltage limit and 2 for trip.
- R3: A read request at address 0 returns the event register contents on `bus_rdata_o` one cycle later with `bus_rvalid_o` high, and clears the register. An edge that arrives in the same cycle as the read stays set afterwards.
- R4: Address 1 holds the event enable mask. Writes store the low 3*NUM_OUT bits, and reads return them with all higher bits zero.
- R5: Status byte bit 0 is the OR over the bitwise AND of the event register and its enable mask. Bits 3 to 1 always read zero. The status byte is read at address 2.
- R6: Status byte bit 5 follows `esb_i` and bit 7 follows `fault_i`.
- R7: Status byte bit 4 is set by a `mav_set_i` pulse and cleared by a `mav_clr_i` pulse. When both pulses arrive in the same cycle, set wins.
- R8: Address 3 holds the service request enable mask. Bit 6 is dropped on write and reads as zero.
- R9: On a status byte read, bit 6 is the live master summary: the OR over the status byte bits other than 6, ANDed with the enable mask.
- R10: A rising edge of the master summary sets the request latch, and `srq_o` goes high the following cycle. A read at address 4 returns the status byte with the latch in bit 6 and clears the latch. The master summary itself is not changed by this read.
- R11: Writes to addresses 0, 2 and 4 have no effect. Reads at addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_lim_i | input | NUM_OUT | Per-output current-limit condition |
| volt_lim_i | input | NUM_OUT | Per-output voltage-limit condition |
| trip_i | input | NUM_OUT | Per-output trip condition |
| esb_i | input | 1 | Precomputed standard-event summary |
| fault_i | input | 1 | Output fault detected |
| mav_set_i | input | 1 | Response message ready pulse |
| mav_clr_i | input | 1 | Response terminator sent pulse |
| bus_req_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid one cycle after request |
| bus_rvalid_o | output | 1 | Read data valid |
| srq_o | output | 1 | Service request |

## Verification
The bench builds the unit with NUM_OUT = 2. This gives six event bits, so the interleaved bit positions of both outputs are exercised. It also leaves the two top enable bits unimplemented, which makes the masking of the readback observable. A table of condition patterns walks rising and falling edges across all six positions and reads the event register back each time. Directed tests then cover a collision between an event and a clear, set-wins on the message flag, and the contrast between the live summary and the latched request.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int DATA_W = 8;
    localparam int N_KIND = 3;

    localparam int KIND_CUR  = 0;
    localparam int KIND_VOLT = 1;
    localparam int KIND_TRIP = 2;

    localparam int BIT_LIM = 0;
    localparam int BIT_MAV = 4;
    localparam int BIT_ESB = 5;
    localparam int BIT_REQ = 6;
    localparam int BIT_FLT = 7;

    typedef enum logic [2:0] {
        ADDR_EVT    = 3'd0,
        ADDR_EVT_EN = 3'd1,
        ADDR_STB    = 3'd2,
        ADDR_SRE    = 3'd3,
        ADDR_POLL   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              req;
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    typedef struct packed {
        logic flt;
        logic esb;
        logic mav;
        logic lim;
    } stb_src_t;

    function automatic logic [DATA_W-1:0] pack_stb(input stb_src_t s, input logic b6);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[BIT_LIM] = s.lim;
        v[BIT_MAV] = s.mav;
        v[BIT_ESB] = s.esb;
        v[BIT_REQ] = b6;
        v[BIT_FLT] = s.flt;
        return v;
    endfunction

    localparam logic [DATA_W-1:0] SRE_KEEP = ~(DATA_W'(1) << BIT_REQ);

endpackage

// File: rtl/stat_edge_detect.sv
module stat_edge_detect #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] cond_q;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond_i;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            assign edge_o[g] = cond_i[g] ^ cond_q[g];
        end
    endgenerate
endmodule

// File: rtl/stat_limit_event.sv
module stat_limit_event #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] edge_i,
    input  logic         clr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o,
    output logic         lim_o
);
    logic [W-1:0] evt_q;
    logic [W-1:0] en_q;
    logic [W-1:0] evt_base;

    always_comb evt_base = clr_i ? '0 : evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= evt_base | edge_i;
            if (en_wr_i) en_q <= en_wdata_i;
        end
    end

    assign evt_o = evt_q;
    assign en_o  = en_q;
    assign lim_o = |(evt_q & en_q);
endmodule

// File: rtl/stat_summary.sv
module stat_summary
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lim_i,
    input  logic              esb_i,
    input  logic              fault_i,
    input  logic              mav_set_i,
    input  logic              mav_clr_i,
    input  logic              sre_wr_i,
    input  logic [DATA_W-1:0] sre_wdata_i,
    input  logic              poll_i,
    output logic [DATA_W-1:0] stb_live_o,
    output logic [DATA_W-1:0] stb_poll_o,
    output logic [DATA_W-1:0] sre_o,
    output logic              mav_o,
    output logic              mss_o,
    output logic              rqs_o
);
    logic              mav_q;
    logic [DATA_W-1:0] sre_q;
    logic              mss_q;
    logic              rqs_q;
    stb_src_t          src;
    logic [DATA_W-1:0] stb_base;
    logic              mss;
    logic              mss_rise;

    always_comb begin
        src.flt  = fault_i;
        src.esb  = esb_i;
        src.mav  = mav_q;
        src.lim  = lim_i;
        stb_base = pack_stb(src, 1'b0);
        mss      = |(stb_base & sre_q);
        mss_rise = mss & ~mss_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mav_q <= 1'b0;
            sre_q <= '0;
            mss_q <= 1'b0;
            rqs_q <= 1'b0;
        end else begin
            if (mav_set_i)      mav_q <= 1'b1;
            else if (mav_clr_i) mav_q <= 1'b0;
            if (sre_wr_i) sre_q <= sre_wdata_i & SRE_KEEP;
            mss_q <= mss;
            if (mss_rise)    rqs_q <= 1'b1;
            else if (poll_i) rqs_q <= 1'b0;
        end
    end

    assign stb_live_o = pack_stb(src, mss);
    assign stb_poll_o = pack_stb(src, rqs_q);
    assign sre_o      = sre_q;
    assign mav_o      = mav_q;
    assign mss_o      = mss;
    assign rqs_o      = rqs_q;
endmodule

// File: rtl/stat_regbus.sv
module stat_regbus
    import stat_pkg::*;
#(
    parameter int EW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd_i,
    input  logic [EW-1:0]     evt_i,
    input  logic [EW-1:0]     evt_en_i,
    input  logic [DATA_W-1:0] stb_live_i,
    input  logic [DATA_W-1:0] stb_poll_i,
    input  logic [DATA_W-1:0] sre_i,
    output logic              evt_clr_o,
    output logic              evt_en_wr_o,
    output logic              sre_wr_o,
    output logic              poll_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    logic              rd;
    logic              wr;
    logic [DATA_W-1:0] rmux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_comb begin
        rd          = cmd_i.req & ~cmd_i.wr;
        wr          = cmd_i.req &  cmd_i.wr;
        evt_clr_o   = rd & (cmd_i.addr == ADDR_EVT);
        poll_o      = rd & (cmd_i.addr == ADDR_POLL);
        evt_en_wr_o = wr & (cmd_i.addr == ADDR_EVT_EN);
        sre_wr_o    = wr & (cmd_i.addr == ADDR_SRE);
        case (cmd_i.addr)
            ADDR_EVT:    rmux = DATA_W'(evt_i);
            ADDR_EVT_EN: rmux = DATA_W'(evt_en_i);
            ADDR_STB:    rmux = stb_live_i;
            ADDR_SRE:    rmux = sre_i;
            ADDR_POLL:   rmux = stb_poll_i;
            default:     rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= rmux;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/stat_report_unit.sv
module stat_report_unit
    import stat_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] cur_lim_i,
    input  logic [NUM_OUT-1:0] volt_lim_i,
    input  logic [NUM_OUT-1:0] trip_i,
    input  logic               esb_i,
    input  logic               fault_i,
    input  logic               mav_set_i,
    input  logic               mav_clr_i,
    input  logic               bus_req_i,
    input  logic               bus_wr_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o,
    output logic               srq_o
);
    localparam int EW = N_KIND * NUM_OUT;

    logic [EW-1:0]     cond_all;
    logic [EW-1:0]     ev_edge;
    logic [EW-1:0]     lev;
    logic [EW-1:0]     lev_en;
    logic              lim;
    logic              evt_clr;
    logic              evt_en_wr;
    logic              sre_wr;
    logic              poll;
    logic [DATA_W-1:0] stb_live;
    logic [DATA_W-1:0] stb_poll;
    logic [DATA_W-1:0] sre;
    logic              mav;
    logic              mss;
    logic              rqs;
    bus_cmd_t          cmd;

    genvar k;
    generate
        for (k = 0; k < NUM_OUT; k++) begin : g_out
            assign cond_all[N_KIND*k + KIND_CUR]  = cur_lim_i[k];
            assign cond_all[N_KIND*k + KIND_VOLT] = volt_lim_i[k];
            assign cond_all[N_KIND*k + KIND_TRIP] = trip_i[k];
        end
    endgenerate

    always_comb begin
        cmd.req   = bus_req_i;
        cmd.wr    = bus_wr_i;
        cmd.addr  = reg_addr_e'(bus_addr_i);
        cmd.wdata = bus_wdata_i;
    end

    stat_edge_detect #(.N(EW)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_all),
        .edge_o (ev_edge)
    );

    stat_limit_event #(.W(EW)) u_evt (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (ev_edge),
        .clr_i      (evt_clr),
        .en_wr_i    (evt_en_wr),
        .en_wdata_i (cmd.wdata[EW-1:0]),
        .evt_o      (lev),
        .en_o       (lev_en),
        .lim_o      (lim)
    );

    stat_summary u_sum (
        .clk         (clk),
        .rst         (rst),
        .lim_i       (lim),
        .esb_i       (esb_i),
        .fault_i     (fault_i),
        .mav_set_i   (mav_set_i),
        .mav_clr_i   (mav_clr_i),
        .sre_wr_i    (sre_wr),
        .sre_wdata_i (cmd.wdata),
        .poll_i      (poll),
        .stb_live_o  (stb_live),
        .stb_poll_o  (stb_poll),
        .sre_o       (sre),
        .mav_o       (mav),
        .mss_o       (mss),
        .rqs_o       (rqs)
    );

    stat_regbus #(.EW(EW)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .evt_i       (lev),
        .evt_en_i    (lev_en),
        .stb_live_i  (stb_live),
        .stb_poll_i  (stb_poll),
        .sre_i       (sre),
        .evt_clr_o   (evt_clr),
        .evt_en_wr_o (evt_en_wr),
        .sre_wr_o    (sre_wr),
        .poll_o      (poll),
        .rdata_o     (bus_rdata_o),
        .rvalid_o    (bus_rvalid_o)
    );

    assign srq_o = rqs;
endmodule

// File: rtl/stat_report_checker.sv
module stat_report_checker #(
    parameter int EW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req_i,
    input logic          bus_wr_i,
    input logic [2:0]    bus_addr_i,
    input logic [7:0]    bus_rdata_o,
    input logic          bus_rvalid_o,
    input logic          srq_o,
    input logic          mav_set_i,
    input logic          mav_clr_i,
    input logic [EW-1:0] ev_edge,
    input logic [EW-1:0] lev,
    input logic [EW-1:0] lev_en,
    input logic          mav,
    input logic          mss
);
    logic rd;
    assign rd = bus_req_i & ~bus_wr_i;

    assert_edge_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_edge != '0) |=> ((lev & $past(ev_edge)) == $past(ev_edge)));

    assert_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == 3'd0) |=>
            (bus_rvalid_o && bus_rdata_o == 8'($past(lev)) && lev == $past(ev_edge)));

    assert_lim_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == 3'd2) |=>
            (bus_rdata_o[0] == $past(|(lev & lev_en)) && bus_rdata_o[3:1] == 3'b000));

    assert_mav_set_R7: assert property (@(posedge clk) disable iff (rst)
        mav_set_i |=> mav);

    assert_mav_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mav_clr_i && !mav_set_i) |=> !mav);

    assert_sre_bit6_R8: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == 3'd3) |=> !bus_rdata_o[6]);

    assert_mss_live_R9: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == 3'd2) |=> (bus_rdata_o[6] == $past(mss)));

    assert_rqs_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (mss && !$past(mss)) |=> srq_o);

    assert_poll_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == 3'd4 && !(mss && !$past(mss))) |=> !srq_o);

    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i > 3'd4) |=> (bus_rdata_o == 8'h00));
endmodule

bind stat_report_unit stat_report_checker #(.EW(EW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_req_i    (bus_req_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .srq_o        (srq_o),
    .mav_set_i    (mav_set_i),
    .mav_clr_i    (mav_clr_i),
    .ev_edge      (ev_edge),
    .lev          (lev),
    .lev_en       (lev_en),
    .mav          (mav),
    .mss          (mss)
);

// File: tb/test_stat_report_unit.sv
module test_stat_report_unit;
    localparam int NOUT = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NOUT-1:0] cur = '0, volt = '0, trip = '0;
    logic            esb = 1'b0, fault = 1'b0, mset = 1'b0, mclr = 1'b0;
    logic            req = 1'b0, wr = 1'b0;
    logic [2:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            rvalid, srq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    stat_report_unit #(.NUM_OUT(NOUT)) i_stat_report_unit (
        .clk(clk), .rst(rst),
        .cur_lim_i(cur), .volt_lim_i(volt), .trip_i(trip),
        .esb_i(esb), .fault_i(fault), .mav_set_i(mset), .mav_clr_i(mclr),
        .bus_req_i(req), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .srq_o(srq)
    );

    // {cur[1:0], volt[1:0], trip[1:0], expected event register}
    localparam logic [13:0] VEC [0:5] = '{
        {2'b01, 2'b00, 2'b00, 8'h01},
        {2'b01, 2'b10, 2'b00, 8'h10},
        {2'b00, 2'b10, 2'b10, 8'h21},
        {2'b00, 2'b10, 2'b10, 8'h00},
        {2'b10, 2'b01, 2'b11, 8'h1E},
        {2'b00, 2'b00, 2'b00, 8'h2E}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d = rvalid ? rdata : 8'hXX;
        req = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 srq", {7'b0, srq}, 8'h00);
        check("R1 rvalid", {7'b0, rvalid}, 8'h00);
        read_check("R1 event reg", 3'd0, 8'h00);
        read_check("R1 event enable", 3'd1, 8'h00);
        read_check("R1 status byte", 3'd2, 8'h00);
        read_check("R1 request enable", 3'd3, 8'h00);
        read_check("R1 serial poll", 3'd4, 8'h00);

        // R2, R3: condition patterns, both edge directions, read and clear
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cur  = VEC[i][13:12];
            volt = VEC[i][11:10];
            trip = VEC[i][9:8];
            idle(3);
            read_check("R2 event latch", 3'd0, VEC[i][7:0]);
        end
        read_check("R3 cleared after read", 3'd0, 8'h00);

        // R3: event in same cycle as read-and-clear survives
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 3'd0; cur[0] = 1'b1;
        @(negedge clk);
        check("R3 collision read value", rdata, 8'h00);
        req = 1'b0;
        read_check("R3 collision event kept", 3'd0, 8'h01);

        // R4: enable mask readback masked to six bits
        bus_write(3'd1, 8'hFF);
        read_check("R4 enable readback", 3'd1, 8'h3F);

        // R5: limit summary bit
        @(negedge clk); volt[1] = 1'b1;
        idle(2);
        read_check("R5 lim set", 3'd2, 8'h01);
        bus_write(3'd1, 8'h01);
        read_check("R5 lim masked off", 3'd2, 8'h00);
        read_check("R5 event kept under mask", 3'd0, 8'h10);

        // R6: esb and fault
        @(negedge clk); esb = 1'b1; fault = 1'b1;
        read_check("R6 esb and fault", 3'd2, 8'hA0);
        @(negedge clk); esb = 1'b0; fault = 1'b0;
        read_check("R6 esb and fault low", 3'd2, 8'h00);

        // R7: message available flag
        @(negedge clk); mset = 1'b1; @(negedge clk); mset = 1'b0;
        read_check("R7 mav set", 3'd2, 8'h10);
        @(negedge clk); mclr = 1'b1; @(negedge clk); mclr = 1'b0;
        read_check("R7 mav cleared", 3'd2, 8'h00);
        @(negedge clk); mset = 1'b1; mclr = 1'b1;
        @(negedge clk); mset = 1'b0; mclr = 1'b0;
        read_check("R7 set wins", 3'd2, 8'h10);
        @(negedge clk); mclr = 1'b1; @(negedge clk); mclr = 1'b0;

        // R8: request enable bit 6 dropped
        bus_write(3'd3, 8'hFF);
        read_check("R8 request enable readback", 3'd3, 8'hBF);
        bus_write(3'd3, 8'h10);
        check("R10 no request yet", {7'b0, srq}, 8'h00);

        // R9, R10: live summary versus latched request
        @(negedge clk); mset = 1'b1; @(negedge clk); mset = 1'b0;
        @(negedge clk);
        check("R10 srq raised", {7'b0, srq}, 8'h01);
        read_check("R9 status live summary", 3'd2, 8'h50);
        read_check("R10 poll returns request", 3'd4, 8'h50);
        check("R10 srq cleared by poll", {7'b0, srq}, 8'h00);
        read_check("R9 summary stays after poll", 3'd2, 8'h50);
        read_check("R10 second poll", 3'd4, 8'h10);
        @(negedge clk); mclr = 1'b1; @(negedge clk); mclr = 1'b0;
        read_check("R9 summary drops", 3'd2, 8'h00);

        // R10 via limit path, then R11
        bus_write(3'd3, 8'h01);
        @(negedge clk); cur[0] = 1'b0;
        idle(2);
        check("R10 srq from limit", {7'b0, srq}, 8'h01);
        bus_write(3'd4, 8'h00);
        check("R11 write to poll ignored", {7'b0, srq}, 8'h01);
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'hFF);
        read_check("R11 write to event reg ignored", 3'd0, 8'h01);
        read_check("R11 unused address", 3'd7, 8'h00);
        read_check("R11 unused address 5", 3'd5, 8'h00);
        read_check("R10 poll after clear", 3'd4, 8'h40);
        check("R10 srq low at end", {7'b0, srq}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule